// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed RISC-V instruction from the RV32C integer subset into the 32-bit base instruction that does the same work. It sits after fetch and before the main decoder, so that decoder only ever sees 32-bit encodings. The block takes a 32-bit word. When its two low bits are `11`, the word is already a full-width instruction and goes through unchanged. Otherwise only the low half is used and the upper half is ignored.

Every compressed code point in quadrants 0, 1 and 2 is classified in one of three ways. It expands to a legal instruction. It expands to a legal instruction that the standard marks as a hint, which raises the hint flag. Or it is reserved, unsupported or custom, which raises the illegal flag and forces the output word to zero. This last class covers the floating-point and 64/128-bit forms, which the block does not handle. Immediates are put back together from their scrambled field positions for each format.

The parameter `REG_OUT` selects one of two output timings. With `REG_OUT=1`, a register stage sits on all outputs and adds one cycle of latency. With `REG_OUT=0`, the path from input to output is purely combinational.

Top module: `cinst_expander`

## Requirements
- R1: If in_instr[1:0] is 11, the output word equals the whole 32-bit input, out_is_comp is 0 and both flags are 0. For any other value, out_is_comp is 1.
- R2: The 3-bit register fields map to x8..x15 by prefixing them with binary 01. C.LW (quadrant 0, funct3 010) becomes lw and C.SW (funct3 110) becomes sw. The zero-extended offset has [5:3] from bits 12:10, [2] from bit 6 and [6] from bit 5. Bits 31:16 of a compressed input have no effect.
- R3: An all-zero low half is illegal. C.ADDI4SPN (quadrant 0, funct3 000) becomes addi rd', x2, nzuimm, with nzuimm[5:4|9:6|2|3] taken from bits 12:5. It is illegal when nzuimm is 0.
- R4: C.ADDI (quadrant 1, funct3 000) becomes addi rd, rd, imm and C.LI (funct3 010) becomes addi rd, x0, imm, where imm = sign-extended {bit12, bits 6:2}. The hint flag is set for C.LI with rd = 0, for C.ADDI with rd != 0 and imm = 0, and for C.ADDI with rd = 0 and imm != 0. The word 0x0001 is a plain nop (0x00000013) with no hint.
- R5: In quadrant 1, funct3 011 with rd = 2 becomes addi x2, x2, imm. Here imm is a multiple of 16 with [9] from bit 12, [4] from bit 6, [6] from bit 5, [8:7] from bits 4:3 and [5] from bit 2. With any other rd it becomes lui rd, with imm[17:12] = {bit12, bits 6:2} sign-extended. Both are illegal when their immediate is 0. The lui form raises the hint flag when rd = 0.
- R6: C.JAL (quadrant 1, funct3 001) becomes jal x1 and C.J (funct3 101) becomes jal x0. The offset is sign-extended from bit 12, with offset[11|4|9:8|10|6|7|3:1|5] taken from bits 12:2.
- R7: C.BEQZ (funct3 110) and C.BNEZ (funct3 111) in quadrant 1 become beq and bne of rs1' against x0. The sign-extended offset has [8|4:3] from bits 12:10 and [7:6|2:1|5] from bits 6:2.
- R8: Quadrant 1 words with bits 15:10 = 100011 become sub, xor, or or and (bits 6:5 = 00, 01, 10, 11) on rd' and rs2'. Words with bits 15:10 = 100111 are illegal.
- R9: C.SRLI, C.SRAI and C.ANDI are selected in quadrant 1, funct3 100, by bits 11:10 = 00, 01 and 10. C.SLLI is quadrant 2, funct3 000. For a shift, a set bit 12 is illegal. A shift amount of zero raises the hint flag, and so does C.SLLI with rd = 0.
- R10: Quadrant 2, funct3 100 decodes as follows. Bit12 = 0 with rs2 = 0 is jalr x0, 0(rs1), and is illegal when rs1 = 0. Bit12 = 0 with rs2 != 0 is add rd, x0, rs2. Bit12 = 1 with rs1 = rs2 = 0 is ebreak. Bit12 = 1 with rs2 = 0 is jalr x1, 0(rs1). Bit12 = 1 with rs2 != 0 is add rd, rd, rs2. Either add form raises the hint flag when rd = 0.
- R11: C.LWSP (quadrant 2, funct3 010) becomes lw rd, uimm(x2), with uimm[5] from bit 12, [4:2] from bits 6:4 and [7:6] from bits 3:2. It is illegal when rd = 0. C.SWSP (funct3 110) becomes sw rs2, uimm(x2), with uimm[5:2] from bits 12:9 and [7:6] from bits 8:7.
- R12: The floating-point and 64/128-bit forms and the reserved funct3 values are illegal. Whenever out_illegal is 1, out_instr is zero and out_hint is 0.
- R13: With REG_OUT=1, every output shows the result for the input of the previous clock edge, and out_valid follows in_valid one cycle later. With REG_OUT=0, the outputs follow the inputs in the same cycle.
- R14: While rst_n is low, the registered outputs are cleared: out_valid = 0 and out_instr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_instr | input | 32 | Fetched word; only bits 15:0 matter when bits 1:0 are not 11 |
| out_valid | output | 1 | Output word is valid |
| out_instr | output | 32 | Expanded 32-bit instruction, zero when illegal |
| out_illegal | output | 1 | Reserved, custom or unsupported compressed code point |
| out_hint | output | 1 | Code point is a standard hint |
| out_is_comp | output | 1 | Input was a compressed instruction |

## Verification
The bench builds two copies: `dut` with `REG_OUT=1` and `dut_comb` with `REG_OUT=0`. Both are driven from one vector table, so every expansion, illegal case and hint case is checked through the register stage and also on the combinational path. Having the registered copy makes it possible to check the one-cycle lag and the reset clearing. Having the combinational copy shows that the same result appears with no latency. The two copies share the same decode logic, so a fault in decoding shows up in both, and a fault in the register stage shows up in only one.

// File: rtl/cx_pkg.sv
// Package: shared types and base-instruction encoders for the compressed
// instruction expander. Assumes RV32 integer base encodings only.
package cx_pkg;
    localparam int INSTR_W = 32;
    localparam int HALF_W  = 16;

    localparam logic [6:0] OP_LOAD  = 7'b0000011;
    localparam logic [6:0] OP_STORE = 7'b0100011;
    localparam logic [6:0] OP_IMM   = 7'b0010011;
    localparam logic [6:0] OP_LUI   = 7'b0110111;
    localparam logic [6:0] OP_REG   = 7'b0110011;
    localparam logic [6:0] OP_JAL   = 7'b1101111;
    localparam logic [6:0] OP_JALR  = 7'b1100111;
    localparam logic [6:0] OP_BR    = 7'b1100011;
    localparam logic [31:0] WORD_EBREAK = 32'h0010_0073;

    // Result of one quadrant decoder.
    typedef struct packed {
        logic [INSTR_W-1:0] word;
        logic               bad;
        logic               hint;
    } xlat_t;

    // Map a 3-bit compact register field onto x8..x15.
    function automatic logic [4:0] prime(input logic [2:0] f);
        return {2'b01, f};
    endfunction

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], OP_STORE};
    endfunction

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd, input logic [6:0] op);
        return {f7, rs2, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] enc_b(input logic [12:1] o, input logic [4:0] rs1,
                                          input logic [2:0] f3);
        return {o[12], o[10:5], 5'd0, rs1, f3, o[4:1], o[11], OP_BR};
    endfunction

    function automatic logic [31:0] enc_j(input logic [20:1] o, input logic [4:0] rd);
        return {o[20], o[10:1], o[11], o[19:12], rd, OP_JAL};
    endfunction
endpackage

// File: rtl/cx_quad0.sv
// Quadrant 0 decoder: stack-pointer add for pointers and register-based
// word load/store. Assumes bits 1:0 were already found to be 00; all
// floating-point and wide forms are reported as bad.
module cx_quad0
    import cx_pkg::*;
(
    input  logic [15:2] c,
    output xlat_t       res
);
    logic [4:0]  rp1, rp2;
    logic [11:0] spn_imm, mem_imm;

    // Field extraction and immediate reassembly.
    always_comb begin
        rp1     = prime(c[9:7]);
        rp2     = prime(c[4:2]);
        spn_imm = {2'b00, c[10:7], c[12:11], c[5], c[6], 2'b00};
        mem_imm = {5'b0, c[5], c[12:10], c[6], 2'b00};
    end

    // Select the expansion by funct3.
    always_comb begin
        res = '{word: '0, bad: 1'b0, hint: 1'b0};
        unique case (c[15:13])
            3'b000: begin
                res.word = enc_i(spn_imm, 5'd2, 3'b000, rp2, OP_IMM);
                res.bad  = (c[12:5] == 8'd0);
            end
            3'b010: res.word = enc_i(mem_imm, rp1, 3'b010, rp2, OP_LOAD);
            3'b110: res.word = enc_s(mem_imm, rp2, rp1, 3'b010);
            default: res.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/cx_quad1.sv
// Quadrant 1 decoder: immediate arithmetic, upper immediate, stack adjust,
// jumps, branches, shifts and register-register ALU forms. Assumes bits 1:0
// were already found to be 01 and RV32 only (word forms reserved).
module cx_quad1
    import cx_pkg::*;
(
    input  logic [15:2] c,
    output xlat_t       res
);
    logic [4:0]  rd, rp1, rp2;
    logic [5:0]  imm6;
    logic [11:0] sx12, sp16;
    logic [20:1] joff;
    logic [12:1] boff;
    logic [2:0]  alu_f3;

    // Field extraction and immediate reassembly.
    always_comb begin
        rd   = c[11:7];
        rp1  = prime(c[9:7]);
        rp2  = prime(c[4:2]);
        imm6 = {c[12], c[6:2]};
        sx12 = {{6{c[12]}}, imm6};
        sp16 = {{3{c[12]}}, c[4:3], c[5], c[2], c[6], 4'b0000};
        joff = {{9{c[12]}}, c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3]};
        boff = {{4{c[12]}}, c[12], c[6:5], c[2], c[11:10], c[4:3]};
        unique case (c[6:5])
            2'b00:   alu_f3 = 3'b000;
            2'b01:   alu_f3 = 3'b100;
            2'b10:   alu_f3 = 3'b110;
            default: alu_f3 = 3'b111;
        endcase
    end

    // Select the expansion by funct3 and sub-fields.
    always_comb begin
        res = '{word: '0, bad: 1'b0, hint: 1'b0};
        unique case (c[15:13])
            3'b000: begin
                res.word = enc_i(sx12, rd, 3'b000, rd, OP_IMM);
                res.hint = (rd == 5'd0) ? (imm6 != 6'd0) : (imm6 == 6'd0);
            end
            3'b001: res.word = enc_j(joff, 5'd1);
            3'b010: begin
                res.word = enc_i(sx12, 5'd0, 3'b000, rd, OP_IMM);
                res.hint = (rd == 5'd0);
            end
            3'b011: begin
                res.bad = (imm6 == 6'd0);
                if (rd == 5'd2) begin
                    res.word = enc_i(sp16, 5'd2, 3'b000, 5'd2, OP_IMM);
                end else begin
                    res.word = {{14{c[12]}}, imm6, rd, OP_LUI};
                    res.hint = (rd == 5'd0);
                end
            end
            3'b100: begin
                unique case (c[11:10])
                    2'b00, 2'b01: begin
                        res.word = enc_r({1'b0, c[10], 5'b0}, c[6:2], rp1, 3'b101, rp1, OP_IMM);
                        res.bad  = c[12];
                        res.hint = (c[6:2] == 5'd0);
                    end
                    2'b10: res.word = enc_i(sx12, rp1, 3'b111, rp1, OP_IMM);
                    default: begin
                        res.word = enc_r({1'b0, (c[6:5] == 2'b00), 5'b0}, rp2, rp1, alu_f3, rp1, OP_REG);
                        res.bad  = c[12];
                    end
                endcase
            end
            3'b101: res.word = enc_j(joff, 5'd0);
            3'b110: res.word = enc_b(boff, rp1, 3'b000);
            default: res.word = enc_b(boff, rp1, 3'b001);
        endcase
    end
endmodule

// File: rtl/cx_quad2.sv
// Quadrant 2 decoder: left shift, stack-pointer word load/store, jump
// register, move, add and ebreak. Assumes bits 1:0 were already found to be
// 10; floating-point and wide forms are reported as bad.
module cx_quad2
    import cx_pkg::*;
(
    input  logic [15:2] c,
    output xlat_t       res
);
    logic [4:0]  rd, rs2;
    logic [11:0] lsp_imm, ssp_imm;

    // Field extraction and immediate reassembly.
    always_comb begin
        rd      = c[11:7];
        rs2     = c[6:2];
        lsp_imm = {4'b0, c[3:2], c[12], c[6:4], 2'b00};
        ssp_imm = {4'b0, c[8:7], c[12:9], 2'b00};
    end

    // Select the expansion by funct3 and sub-fields.
    always_comb begin
        res = '{word: '0, bad: 1'b0, hint: 1'b0};
        unique case (c[15:13])
            3'b000: begin
                res.word = enc_r(7'd0, rs2, rd, 3'b001, rd, OP_IMM);
                res.bad  = c[12];
                res.hint = (rd == 5'd0) || (rs2 == 5'd0);
            end
            3'b010: begin
                res.word = enc_i(lsp_imm, 5'd2, 3'b010, rd, OP_LOAD);
                res.bad  = (rd == 5'd0);
            end
            3'b100: begin
                if (rs2 == 5'd0) begin
                    if (!c[12]) begin
                        res.word = enc_i(12'd0, rd, 3'b000, 5'd0, OP_JALR);
                        res.bad  = (rd == 5'd0);
                    end else if (rd == 5'd0) begin
                        res.word = WORD_EBREAK;
                    end else begin
                        res.word = enc_i(12'd0, rd, 3'b000, 5'd1, OP_JALR);
                    end
                end else begin
                    res.word = enc_r(7'd0, rs2, c[12] ? rd : 5'd0, 3'b000, rd, OP_REG);
                    res.hint = (rd == 5'd0);
                end
            end
            3'b110: res.word = enc_s(ssp_imm, rs2, 5'd2, 3'b010);
            default: res.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/cinst_expander.sv
// Top: expands RV32C integer compressed instructions into 32-bit base
// instructions, passes full-width words through, flags illegal and hint
// code points, and optionally registers all outputs (REG_OUT).
// Assumes a synchronous active-low reset; illegal results carry a zero word.
module cinst_expander
    import cx_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    output logic               out_valid,
    output logic [INSTR_W-1:0] out_instr,
    output logic               out_illegal,
    output logic               out_hint,
    output logic               out_is_comp
);
    xlat_t              q0_res, q1_res, q2_res, sel;
    logic [INSTR_W-1:0] nx_word;
    logic               nx_bad, nx_hint, nx_comp;

    cx_quad0 u_q0 (.c(in_instr[HALF_W-1:2]), .res(q0_res));
    cx_quad1 u_q1 (.c(in_instr[HALF_W-1:2]), .res(q1_res));
    cx_quad2 u_q2 (.c(in_instr[HALF_W-1:2]), .res(q2_res));

    // Pick the quadrant result or pass a full-width word through.
    always_comb begin
        unique case (in_instr[1:0])
            2'b00:   sel = q0_res;
            2'b01:   sel = q1_res;
            2'b10:   sel = q2_res;
            default: sel = '{word: in_instr, bad: 1'b0, hint: 1'b0};
        endcase
        nx_comp = (in_instr[1:0] != 2'b11);
        nx_bad  = sel.bad;
        nx_hint = sel.hint & ~sel.bad;
        nx_word = sel.bad ? '0 : sel.word;
    end

    generate
        if (REG_OUT) begin : g_reg
            // Output stage: capture the expansion each cycle, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid   <= 1'b0;
                    out_instr   <= '0;
                    out_illegal <= 1'b0;
                    out_hint    <= 1'b0;
                    out_is_comp <= 1'b0;
                end else begin
                    out_valid   <= in_valid;
                    out_instr   <= nx_word;
                    out_illegal <= nx_bad;
                    out_hint    <= nx_hint;
                    out_is_comp <= nx_comp;
                end
            end

            // R13: registered outputs lag the decode by exactly one cycle.
            assert_one_cycle_lag_R13: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (out_valid == $past(in_valid) && out_instr == $past(nx_word)));
            // R14: reset clears the output stage.
            assert_reset_clear_R14: assert property (@(posedge clk)
                !rst_n |=> (!out_valid && out_instr == '0));
        end else begin : g_comb
            // Combinational outputs.
            always_comb begin
                out_valid   = in_valid;
                out_instr   = nx_word;
                out_illegal = nx_bad;
                out_hint    = nx_hint;
                out_is_comp = nx_comp;
            end
        end
    endgenerate

    // R1: full-width words leave unchanged and unmarked.
    assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_instr[1:0] == 2'b11) |-> (nx_word == in_instr && !nx_comp && !nx_bad));
    // R3: an all-zero half word is never accepted.
    assert_zero_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_instr[HALF_W-1:0] == 16'h0000) |-> nx_bad);
    // R8: upper arithmetic group is reserved on RV32.
    assert_ca_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_instr[1:0] == 2'b01 && in_instr[15:10] == 6'b100111) |-> nx_bad);
    // R9: shift amounts of 32 or more are rejected.
    assert_shamt_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_instr[1:0] == 2'b01 && in_instr[15:12] == 4'b1001 && !in_instr[11]) ||
         (in_instr[1:0] == 2'b10 && in_instr[15:12] == 4'b0001)) |-> nx_bad);
    // R11: stack load into x0 is reserved.
    assert_lwsp_rd0_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_instr[1:0] == 2'b10 && in_instr[15:13] == 3'b010 && in_instr[11:7] == 5'd0) |-> nx_bad);
    // R12: an illegal result carries a zero word and no hint.
    assert_illegal_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_instr == '0 && !out_hint));
endmodule

// File: tb/tb_cinst_expander.sv
module tb_cinst_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = 32'h0;
    logic        r_valid, r_ill, r_hint, r_comp;
    logic [31:0] r_instr;
    logic        c_valid, c_ill, c_hint, c_comp;
    logic [31:0] c_instr;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    cinst_expander #(.REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .out_valid(r_valid), .out_instr(r_instr), .out_illegal(r_ill),
        .out_hint(r_hint), .out_is_comp(r_comp));

    cinst_expander #(.REG_OUT(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .out_valid(c_valid), .out_instr(c_instr), .out_illegal(c_ill),
        .out_hint(c_hint), .out_is_comp(c_comp));

    // Vector: [79:48] input, [47:16] expected word, [15:8] requirement, [1] illegal, [0] hint
    localparam int NV = 48;
    localparam logic [79:0] VEC [NV] = '{
        {32'h0000_4144, 32'h0045_2483, 8'd2,  8'h00}, // R2 lw x9,4(x10)
        {32'h0000_C02C, 32'h04B4_2023, 8'd2,  8'h00}, // R2 sw x11,64(x8)
        {32'hDEAD_4144, 32'h0045_2483, 8'd2,  8'h00}, // R2 upper half ignored
        {32'h0000_0020, 32'h0081_0413, 8'd3,  8'h00}, // R3 addi x8,x2,8
        {32'h0000_0000, 32'h0000_0000, 8'd3,  8'h02}, // R3 zero word
        {32'h0000_0004, 32'h0000_0000, 8'd3,  8'h02}, // R3 nzuimm 0
        {32'h0000_52FD, 32'hFFF0_0293, 8'd4,  8'h00}, // R4 li x5,-1
        {32'h0000_400D, 32'h0030_0013, 8'd4,  8'h01}, // R4 li x0 hint
        {32'h0000_0001, 32'h0000_0013, 8'd4,  8'h00}, // R4 nop
        {32'h0000_0005, 32'h0010_0013, 8'd4,  8'h01}, // R4 addi x0,1 hint
        {32'h0000_0501, 32'h0005_0513, 8'd4,  8'h01}, // R4 addi x10,0 hint
        {32'h0000_717D, 32'hFF01_0113, 8'd5,  8'h00}, // R5 addi sp,-16
        {32'h0000_6101, 32'h0000_0000, 8'd5,  8'h02}, // R5 sp adjust 0
        {32'h0000_6185, 32'h0000_11B7, 8'd5,  8'h00}, // R5 lui x3,1
        {32'h0000_6005, 32'h0000_1037, 8'd5,  8'h01}, // R5 lui x0 hint
        {32'h0000_6181, 32'h0000_0000, 8'd5,  8'h02}, // R5 lui 0
        {32'h0000_BFFD, 32'hFFFF_F06F, 8'd6,  8'h00}, // R6 j -2
        {32'h0000_2009, 32'h0020_00EF, 8'd6,  8'h00}, // R6 jal +2
        {32'h0000_C401, 32'h0004_0463, 8'd7,  8'h00}, // R7 beqz x8,+8
        {32'h0000_FFF5, 32'hFE07_9EE3, 8'd7,  8'h00}, // R7 bnez x15,-4
        {32'h0000_8C05, 32'h4094_0433, 8'd8,  8'h00}, // R8 sub
        {32'h0000_8C25, 32'h0094_4433, 8'd8,  8'h00}, // R8 xor
        {32'h0000_8C45, 32'h0094_6433, 8'd8,  8'h00}, // R8 or
        {32'h0000_8C65, 32'h0094_7433, 8'd8,  8'h00}, // R8 and
        {32'h0000_9C05, 32'h0000_0000, 8'd8,  8'h02}, // R8 word-sub reserved
        {32'h0000_9C45, 32'h0000_0000, 8'd8,  8'h02}, // R8 reserved
        {32'h0000_808D, 32'h0034_D493, 8'd9,  8'h00}, // R9 srli x9,3
        {32'h0000_848D, 32'h4034_D493, 8'd9,  8'h00}, // R9 srai x9,3
        {32'h0000_9081, 32'h0000_0000, 8'd9,  8'h02}, // R9 shamt[5]
        {32'h0000_8081, 32'h0004_D493, 8'd9,  8'h01}, // R9 srli 0 hint
        {32'h0000_98F9, 32'hFFE4_F493, 8'd9,  8'h00}, // R9 andi x9,-2
        {32'h0000_0512, 32'h0045_1513, 8'd9,  8'h00}, // R9 slli x10,4
        {32'h0000_0012, 32'h0040_1013, 8'd9,  8'h01}, // R9 slli x0 hint
        {32'h0000_1512, 32'h0000_0000, 8'd9,  8'h02}, // R9 slli shamt[5]
        {32'h0000_8082, 32'h0000_8067, 8'd10, 8'h00}, // R10 jr x1
        {32'h0000_8002, 32'h0000_0000, 8'd10, 8'h02}, // R10 jr x0
        {32'h0000_852E, 32'h00B0_0533, 8'd10, 8'h00}, // R10 mv x10,x11
        {32'h0000_802E, 32'h00B0_0033, 8'd10, 8'h01}, // R10 mv x0 hint
        {32'h0000_9002, 32'h0010_0073, 8'd10, 8'h00}, // R10 ebreak
        {32'h0000_9282, 32'h0002_80E7, 8'd10, 8'h00}, // R10 jalr x5
        {32'h0000_952E, 32'h00B5_0533, 8'd10, 8'h00}, // R10 add x10,x11
        {32'h0000_902E, 32'h00B0_0033, 8'd10, 8'h01}, // R10 add x0 hint
        {32'h0000_42A2, 32'h0081_2283, 8'd11, 8'h00}, // R11 lwsp x5,8
        {32'h0000_4022, 32'h0000_0000, 8'd11, 8'h02}, // R11 lwsp x0
        {32'h0000_C21A, 32'h0061_2223, 8'd11, 8'h00}, // R11 swsp x6,4
        {32'h0000_2000, 32'h0000_0000, 8'd12, 8'h02}, // R12 fp load
        {32'h0000_8000, 32'h0000_0000, 8'd12, 8'h02}, // R12 reserved funct3
        {32'h00A0_0093, 32'h00A0_0093, 8'd1,  8'h00}  // R1 full-width pass
    };

    task automatic chk(input int tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_set(input int tag, input logic v, input logic [31:0] w,
                           input logic il, input logic h, input logic cp,
                           input logic [31:0] ew, input logic eil, input logic eh,
                           input logic ecp);
        chk(tag, "valid", {31'd0, v}, 32'd1);
        chk(tag, "word", w, ew);
        chk(tag, "illegal", {31'd0, il}, {31'd0, eil});
        chk(tag, "hint", {31'd0, h}, {31'd0, eh});
        chk(tag, "is_comp", {31'd0, cp}, {31'd0, ecp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R14: reset clears registered outputs even with valid input
        in_valid = 1'b1;
        in_instr = 32'h0000_4144;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(14, "reset valid", {31'd0, r_valid}, 32'd0);
        chk(14, "reset word", r_instr, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [79:0] v;
            logic        ecp;
            v = VEC[i];
            ecp = (v[49:48] != 2'b11);
            @(negedge clk);
            in_instr = v[79:48];
            in_valid = 1'b1;
            #2;
            chk_set(int'(v[15:8]), c_valid, c_instr, c_ill, c_hint, c_comp,
                    v[47:16], v[1], v[0], ecp);
            @(negedge clk);
            chk_set(int'(v[15:8]), r_valid, r_instr, r_ill, r_hint, r_comp,
                    v[47:16], v[1], v[0], ecp);
        end

        // R13: one-cycle lag of registered copy versus the combinational copy
        @(negedge clk);
        in_instr = 32'h0000_8C05;
        in_valid = 1'b1;
        @(negedge clk);
        in_instr = 32'h0000_8C25;
        in_valid = 1'b0;
        #2;
        chk(13, "held word", r_instr, 32'h4094_0433);
        chk(13, "held valid", {31'd0, r_valid}, 32'd1);
        chk(13, "comb valid", {31'd0, c_valid}, 32'd0);
        chk(13, "comb word", c_instr, 32'h0094_4433);
        @(negedge clk);
        chk(13, "lagged valid", {31'd0, r_valid}, 32'd0);
        chk(13, "lagged word", r_instr, 32'h0094_4433);

        // R14: reset in mid-run clears the stage
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk(14, "rerun reset valid", {31'd0, r_valid}, 32'd0);
        chk(14, "rerun reset word", r_instr, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule